// File: doc/BRIEF.md
# AXI Clock-Domain Bridge

This block carries a complete AXI4 link between two clocks that have no fixed relation. A manager in the source clock domain connects to the subordinate-side port; the master-side port, clocked by the destination clock, connects onward to the real subordinate. Write address, write data and read address requests travel from source to destination. Write responses and read data travel the other way.

Each of the five channels has its own dual-clock queue. A queue stores the whole channel word (identifiers, address, data, strobes, response code, last flag) in a small memory. That memory is written on the producer's clock and read on the consumer's clock. Only the Gray-coded queue pointers pass through synchronizer flops. A word is offered to the consumer only after the consumer side can see that it was written. Because the word travels with its handshake as one entry, the VALID/READY rules hold on both sides.

Each side has an asynchronous active-low reset, released synchronously inside the bridge. Queue depths and the length of the synchronizer chains are parameters. Depths must be powers of two and at least 4. Chains must be at least two flops long.

Top module: `xclk_axi_bridge`

## Requirements
- R1: On every channel, beats leave the bridge in the order they entered, each with a payload bit-identical to the one accepted, with none lost and none repeated.
- R2: Write address, write data and read address beats accepted on the s_clk port appear on the m_clk port; write response and read data beats accepted on the m_clk port appear on the s_clk port.
- R3: When an output VALID is high and its READY is low at a clock edge of that side, VALID is still high after the edge and every payload field of that channel is unchanged.
- R4: A channel accepts a beat only on an edge where its input VALID and READY are both high. If the far side never drains, a channel accepts exactly its queue depth of beats (4 in the default small setup) and then holds READY low.
- R5: While a side's reset input is low, all READY and VALID outputs of that side are low. After both resets release with no traffic, all READY outputs are high and all VALID outputs stay low.
- R6: A channel whose consumer stalls indefinitely does not hold back beats on any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Source-side clock |
| s_rst_n | input | 1 | Source-side reset, active low, asynchronous assert |
| s_awvalid | input | 1 | Write address offered |
| s_awready | output | 1 | Write address queue has room |
| s_awid | input | ID_W | Write transaction identifier |
| s_awaddr | input | ADDR_W | Write address |
| s_awlen | input | 8 | Write burst beat count minus one |
| s_awsize | input | 3 | Write beat size code |
| s_awburst | input | 2 | Write burst type |
| s_awprot | input | 3 | Write protection attributes |
| s_wvalid | input | 1 | Write data offered |
| s_wready | output | 1 | Write data queue has room |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte enables |
| s_wlast | input | 1 | Final write beat of a burst |
| s_bvalid | output | 1 | Write response available |
| s_bready | input | 1 | Write response taken |
| s_bid | output | ID_W | Write response identifier |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address offered |
| s_arready | output | 1 | Read address queue has room |
| s_arid | input | ID_W | Read transaction identifier |
| s_araddr | input | ADDR_W | Read address |
| s_arlen | input | 8 | Read burst beat count minus one |
| s_arsize | input | 3 | Read beat size code |
| s_arburst | input | 2 | Read burst type |
| s_arprot | input | 3 | Read protection attributes |
| s_rvalid | output | 1 | Read data available |
| s_rready | input | 1 | Read data taken |
| s_rid | output | ID_W | Read data identifier |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Final read beat of a burst |
| m_clk | input | 1 | Destination-side clock |
| m_rst_n | input | 1 | Destination-side reset, active low, asynchronous assert |
| m_awvalid | output | 1 | Write address available |
| m_awready | input | 1 | Write address taken |
| m_awid | output | ID_W | Write transaction identifier |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Write burst beat count minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awprot | output | 3 | Write protection attributes |
| m_wvalid | output | 1 | Write data available |
| m_wready | input | 1 | Write data taken |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte enables |
| m_wlast | output | 1 | Final write beat of a burst |
| m_bvalid | input | 1 | Write response offered |
| m_bready | output | 1 | Write response queue has room |
| m_bid | input | ID_W | Write response identifier |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address available |
| m_arready | input | 1 | Read address taken |
| m_arid | output | ID_W | Read transaction identifier |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Read burst beat count minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arprot | output | 3 | Read protection attributes |
| m_rvalid | input | 1 | Read data offered |
| m_rready | output | 1 | Read data queue has room |
| m_rid | input | ID_W | Read data identifier |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Final read beat of a burst |

## Verification
The bench runs the two clocks at unrelated periods. It applies random stalls at both ends of all five channels, so pointer updates arrive at the far side with varying lag. Each beat's payload is a closed-form function of its index, so a swapped, repeated or skipped entry shows up as a mismatch or a count error. A full-detection error that treats the pointer wrap wrongly would accept a fifth beat and overwrite an unread entry, or would stop early. The bench catches either case by stalling the write-address consumer and counting the beats accepted. While that channel is stalled, write data must still flow; a design that shares state between queues would stall there. Checks during and after reset catch READY raised before the side is out of reset, and VALID raised when the queue is empty.

// File: rtl/xclk_pkg.sv
package xclk_pkg;
   localparam int LEN_W   = 8;
   localparam int SIZE_W  = 3;
   localparam int BURST_W = 2;
   localparam int PROT_W  = 3;
   localparam int RESP_W  = 2;

   // queue depth must be a power of two and hold at least four entries
   function automatic bit depth_ok(input int d);
      return (d >= 4) && ((d & (d - 1)) == 0);
   endfunction
endpackage

// File: rtl/xclk_rst_sync.sv
module xclk_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xclk_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/xclk_ptr_sync.sv
module xclk_ptr_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xclk_ptr_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= '0;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
   parameter int WIDTH       = 8,
   parameter int DEPTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wclk,
   input  logic             wrst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   input  logic             rclk,
   input  logic             rrst_n,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if (!xclk_pkg::depth_ok(DEPTH)) begin : g_bad_depth
         $error("xclk_fifo: DEPTH must be a power of two and at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];

   // writer side
   logic [PW-1:0] wbin, wgray, wbin_nx, rgray_at_w;
   logic          push, full;

   assign push    = in_valid && in_ready;
   assign wbin_nx = wbin + PW'(push);

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   always_ff @(posedge wclk) begin
      if (push) mem[wbin[AW-1:0]] <= in_data;
   end

   xclk_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_to_w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_at_w)
   );

   assign full     = (wgray == {~rgray_at_w[PW-1:PW-2], rgray_at_w[PW-3:0]});
   assign in_ready = wrst_n && !full;

   // reader side
   logic [PW-1:0] rbin, rgray, rbin_nx, wgray_at_r;
   logic          pop, empty;

   assign pop     = out_valid && out_ready;
   assign rbin_nx = rbin + PW'(pop);

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
   end

   xclk_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_to_r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_at_r)
   );

   assign empty     = (rgray == wgray_at_r);
   assign out_valid = !empty;
   assign out_data  = mem[rbin[AW-1:0]];
endmodule

// File: rtl/xclk_axi_bridge.sv
module xclk_axi_bridge
   import xclk_pkg::*;
#(
   parameter int ID_W        = 4,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int REQ_DEPTH   = 8,
   parameter int RSP_DEPTH   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                s_clk,
   input  logic                s_rst_n,
   input  logic                s_awvalid,
   output logic                s_awready,
   input  logic [ID_W-1:0]     s_awid,
   input  logic [ADDR_W-1:0]   s_awaddr,
   input  logic [7:0]          s_awlen,
   input  logic [2:0]          s_awsize,
   input  logic [1:0]          s_awburst,
   input  logic [2:0]          s_awprot,
   input  logic                s_wvalid,
   output logic                s_wready,
   input  logic [DATA_W-1:0]   s_wdata,
   input  logic [DATA_W/8-1:0] s_wstrb,
   input  logic                s_wlast,
   output logic                s_bvalid,
   input  logic                s_bready,
   output logic [ID_W-1:0]     s_bid,
   output logic [1:0]          s_bresp,
   input  logic                s_arvalid,
   output logic                s_arready,
   input  logic [ID_W-1:0]     s_arid,
   input  logic [ADDR_W-1:0]   s_araddr,
   input  logic [7:0]          s_arlen,
   input  logic [2:0]          s_arsize,
   input  logic [1:0]          s_arburst,
   input  logic [2:0]          s_arprot,
   output logic                s_rvalid,
   input  logic                s_rready,
   output logic [ID_W-1:0]     s_rid,
   output logic [DATA_W-1:0]   s_rdata,
   output logic [1:0]          s_rresp,
   output logic                s_rlast,
   input  logic                m_clk,
   input  logic                m_rst_n,
   output logic                m_awvalid,
   input  logic                m_awready,
   output logic [ID_W-1:0]     m_awid,
   output logic [ADDR_W-1:0]   m_awaddr,
   output logic [7:0]          m_awlen,
   output logic [2:0]          m_awsize,
   output logic [1:0]          m_awburst,
   output logic [2:0]          m_awprot,
   output logic                m_wvalid,
   input  logic                m_wready,
   output logic [DATA_W-1:0]   m_wdata,
   output logic [DATA_W/8-1:0] m_wstrb,
   output logic                m_wlast,
   input  logic                m_bvalid,
   output logic                m_bready,
   input  logic [ID_W-1:0]     m_bid,
   input  logic [1:0]          m_bresp,
   output logic                m_arvalid,
   input  logic                m_arready,
   output logic [ID_W-1:0]     m_arid,
   output logic [ADDR_W-1:0]   m_araddr,
   output logic [7:0]          m_arlen,
   output logic [2:0]          m_arsize,
   output logic [1:0]          m_arburst,
   output logic [2:0]          m_arprot,
   input  logic                m_rvalid,
   output logic                m_rready,
   input  logic [ID_W-1:0]     m_rid,
   input  logic [DATA_W-1:0]   m_rdata,
   input  logic [1:0]          m_rresp,
   input  logic                m_rlast
);
   localparam int STRB_W = DATA_W / 8;
   localparam int A_BITS = ID_W + ADDR_W + LEN_W + SIZE_W + BURST_W + PROT_W;
   localparam int W_BITS = DATA_W + STRB_W + 1;
   localparam int B_BITS = ID_W + RESP_W;
   localparam int R_BITS = ID_W + DATA_W + RESP_W + 1;

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
         $error("xclk_axi_bridge: DATA_W must be a multiple of 8");
      end
   endgenerate

   logic s_rst_q, m_rst_q;

   xclk_rst_sync #(.STAGES(SYNC_STAGES)) u_s_rst (
      .clk(s_clk), .arst_n(s_rst_n), .srst_n(s_rst_q)
   );
   xclk_rst_sync #(.STAGES(SYNC_STAGES)) u_m_rst (
      .clk(m_clk), .arst_n(m_rst_n), .srst_n(m_rst_q)
   );

   logic [A_BITS-1:0] aw_in, aw_out, ar_in, ar_out;
   logic [W_BITS-1:0] w_in, w_out;
   logic [B_BITS-1:0] b_in, b_out;
   logic [R_BITS-1:0] r_in, r_out;

   assign aw_in = {s_awid, s_awaddr, s_awlen, s_awsize, s_awburst, s_awprot};
   assign {m_awid, m_awaddr, m_awlen, m_awsize, m_awburst, m_awprot} = aw_out;
   assign w_in  = {s_wdata, s_wstrb, s_wlast};
   assign {m_wdata, m_wstrb, m_wlast} = w_out;
   assign ar_in = {s_arid, s_araddr, s_arlen, s_arsize, s_arburst, s_arprot};
   assign {m_arid, m_araddr, m_arlen, m_arsize, m_arburst, m_arprot} = ar_out;
   assign b_in  = {m_bid, m_bresp};
   assign {s_bid, s_bresp} = b_out;
   assign r_in  = {m_rid, m_rdata, m_rresp, m_rlast};
   assign {s_rid, s_rdata, s_rresp, s_rlast} = r_out;

   xclk_fifo #(.WIDTH(A_BITS), .DEPTH(REQ_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_aw_q (
      .wclk(s_clk), .wrst_n(s_rst_q), .in_valid(s_awvalid), .in_ready(s_awready), .in_data(aw_in),
      .rclk(m_clk), .rrst_n(m_rst_q), .out_valid(m_awvalid), .out_ready(m_awready), .out_data(aw_out)
   );

   xclk_fifo #(.WIDTH(W_BITS), .DEPTH(REQ_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_w_q (
      .wclk(s_clk), .wrst_n(s_rst_q), .in_valid(s_wvalid), .in_ready(s_wready), .in_data(w_in),
      .rclk(m_clk), .rrst_n(m_rst_q), .out_valid(m_wvalid), .out_ready(m_wready), .out_data(w_out)
   );

   xclk_fifo #(.WIDTH(A_BITS), .DEPTH(REQ_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ar_q (
      .wclk(s_clk), .wrst_n(s_rst_q), .in_valid(s_arvalid), .in_ready(s_arready), .in_data(ar_in),
      .rclk(m_clk), .rrst_n(m_rst_q), .out_valid(m_arvalid), .out_ready(m_arready), .out_data(ar_out)
   );

   xclk_fifo #(.WIDTH(B_BITS), .DEPTH(RSP_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_b_q (
      .wclk(m_clk), .wrst_n(m_rst_q), .in_valid(m_bvalid), .in_ready(m_bready), .in_data(b_in),
      .rclk(s_clk), .rrst_n(s_rst_q), .out_valid(s_bvalid), .out_ready(s_bready), .out_data(b_out)
   );

   xclk_fifo #(.WIDTH(R_BITS), .DEPTH(RSP_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_r_q (
      .wclk(m_clk), .wrst_n(m_rst_q), .in_valid(m_rvalid), .in_ready(m_rready), .in_data(r_in),
      .rclk(s_clk), .rrst_n(s_rst_q), .out_valid(s_rvalid), .out_ready(s_rready), .out_data(r_out)
   );
endmodule

// File: rtl/xclk_axi_bridge_chk.sv
module xclk_axi_bridge_chk #(
   parameter int ID_W   = 4,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                s_clk,
   input logic                s_rst_n,
   input logic                s_awready,
   input logic                s_wready,
   input logic                s_arready,
   input logic                s_bvalid,
   input logic                s_bready,
   input logic [ID_W-1:0]     s_bid,
   input logic [1:0]          s_bresp,
   input logic                s_rvalid,
   input logic                s_rready,
   input logic [ID_W-1:0]     s_rid,
   input logic [DATA_W-1:0]   s_rdata,
   input logic [1:0]          s_rresp,
   input logic                s_rlast,
   input logic                m_clk,
   input logic                m_rst_n,
   input logic                m_awvalid,
   input logic                m_awready,
   input logic [ID_W-1:0]     m_awid,
   input logic [ADDR_W-1:0]   m_awaddr,
   input logic [7:0]          m_awlen,
   input logic [2:0]          m_awsize,
   input logic [1:0]          m_awburst,
   input logic [2:0]          m_awprot,
   input logic                m_wvalid,
   input logic                m_wready,
   input logic [DATA_W-1:0]   m_wdata,
   input logic [DATA_W/8-1:0] m_wstrb,
   input logic                m_wlast,
   input logic                m_bready,
   input logic                m_arvalid,
   input logic                m_arready,
   input logic [ID_W-1:0]     m_arid,
   input logic [ADDR_W-1:0]   m_araddr,
   input logic [7:0]          m_arlen,
   input logic [2:0]          m_arsize,
   input logic [1:0]          m_arburst,
   input logic [2:0]          m_arprot,
   input logic                m_rready
);
   // R3: a beat on offer stays on offer, unchanged, until taken
   p_hold_aw_r3: assert property (@(posedge m_clk) disable iff (!m_rst_n)
      (m_awvalid && !m_awready) |=> (m_awvalid &&
         $stable({m_awid, m_awaddr, m_awlen, m_awsize, m_awburst, m_awprot})));

   p_hold_w_r3: assert property (@(posedge m_clk) disable iff (!m_rst_n)
      (m_wvalid && !m_wready) |=> (m_wvalid && $stable({m_wdata, m_wstrb, m_wlast})));

   p_hold_ar_r3: assert property (@(posedge m_clk) disable iff (!m_rst_n)
      (m_arvalid && !m_arready) |=> (m_arvalid &&
         $stable({m_arid, m_araddr, m_arlen, m_arsize, m_arburst, m_arprot})));

   p_hold_b_r3: assert property (@(posedge s_clk) disable iff (!s_rst_n)
      (s_bvalid && !s_bready) |=> (s_bvalid && $stable({s_bid, s_bresp})));

   p_hold_r_r3: assert property (@(posedge s_clk) disable iff (!s_rst_n)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable({s_rid, s_rdata, s_rresp, s_rlast})));

   // R5: a side held in reset offers nothing and accepts nothing
   always @(posedge s_clk) begin
      if (!s_rst_n) begin
         p_quiet_s_r5: assert (!s_awready && !s_wready && !s_arready && !s_bvalid && !s_rvalid);
      end
   end

   always @(posedge m_clk) begin
      if (!m_rst_n) begin
         p_quiet_m_r5: assert (!m_awvalid && !m_wvalid && !m_arvalid && !m_bready && !m_rready);
      end
   end
endmodule

bind xclk_axi_bridge xclk_axi_bridge_chk #(
   .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .s_clk(s_clk), .s_rst_n(s_rst_n),
   .s_awready(s_awready), .s_wready(s_wready), .s_arready(s_arready),
   .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
   .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid), .s_rdata(s_rdata),
   .s_rresp(s_rresp), .s_rlast(s_rlast),
   .m_clk(m_clk), .m_rst_n(m_rst_n),
   .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awid(m_awid), .m_awaddr(m_awaddr),
   .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst), .m_awprot(m_awprot),
   .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
   .m_wlast(m_wlast), .m_bready(m_bready),
   .m_arvalid(m_arvalid), .m_arready(m_arready), .m_arid(m_arid), .m_araddr(m_araddr),
   .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst), .m_arprot(m_arprot),
   .m_rready(m_rready)
);

// File: tb/xclk_axi_bridge_test.sv
`timescale 1ns/1ps
module xclk_axi_bridge_test;
   localparam int ID_W  = 2;
   localparam int ADR_W = 8;
   localparam int DAT_W = 8;
   localparam int DEPTH = 4;
   localparam int N     = 64;
   localparam int A_B   = ID_W + ADR_W + 8 + 3 + 2 + 3;
   localparam int W_B   = DAT_W + DAT_W/8 + 1;
   localparam int B_B   = ID_W + 2;
   localparam int R_B   = ID_W + DAT_W + 2 + 1;

   logic s_clk = 0, m_clk = 0;
   logic s_rst_n = 0, m_rst_n = 0;
   always #10   s_clk = ~s_clk;
   always #13.5 m_clk = ~m_clk;

   logic s_awvalid = 0, s_awready; logic [ID_W-1:0] s_awid = 0; logic [ADR_W-1:0] s_awaddr = 0;
   logic [7:0] s_awlen = 0; logic [2:0] s_awsize = 0; logic [1:0] s_awburst = 0; logic [2:0] s_awprot = 0;
   logic s_wvalid = 0, s_wready; logic [DAT_W-1:0] s_wdata = 0; logic [DAT_W/8-1:0] s_wstrb = 0; logic s_wlast = 0;
   logic s_bvalid, s_bready = 0; logic [ID_W-1:0] s_bid; logic [1:0] s_bresp;
   logic s_arvalid = 0, s_arready; logic [ID_W-1:0] s_arid = 0; logic [ADR_W-1:0] s_araddr = 0;
   logic [7:0] s_arlen = 0; logic [2:0] s_arsize = 0; logic [1:0] s_arburst = 0; logic [2:0] s_arprot = 0;
   logic s_rvalid, s_rready = 0; logic [ID_W-1:0] s_rid; logic [DAT_W-1:0] s_rdata; logic [1:0] s_rresp; logic s_rlast;
   logic m_awvalid, m_awready = 0; logic [ID_W-1:0] m_awid; logic [ADR_W-1:0] m_awaddr;
   logic [7:0] m_awlen; logic [2:0] m_awsize; logic [1:0] m_awburst; logic [2:0] m_awprot;
   logic m_wvalid, m_wready = 0; logic [DAT_W-1:0] m_wdata; logic [DAT_W/8-1:0] m_wstrb; logic m_wlast;
   logic m_bvalid = 0, m_bready; logic [ID_W-1:0] m_bid = 0; logic [1:0] m_bresp = 0;
   logic m_arvalid, m_arready = 0; logic [ID_W-1:0] m_arid; logic [ADR_W-1:0] m_araddr;
   logic [7:0] m_arlen; logic [2:0] m_arsize; logic [1:0] m_arburst; logic [2:0] m_arprot;
   logic m_rvalid = 0, m_rready; logic [ID_W-1:0] m_rid = 0; logic [DAT_W-1:0] m_rdata = 0;
   logic [1:0] m_rresp = 0; logic m_rlast = 0;

   xclk_axi_bridge #(.ID_W(ID_W), .ADDR_W(ADR_W), .DATA_W(DAT_W), .REQ_DEPTH(DEPTH),
                     .RSP_DEPTH(DEPTH), .SYNC_STAGES(2)) uut (.*);

   int checks = 0, errors = 0;
   bit go = 0, aw_en = 0, done = 0;
   int aw_sent = 0, w_sent = 0, ar_sent = 0, b_sent = 0, r_sent = 0;
   int aw_got = 0, w_got = 0, ar_got = 0, b_got = 0, r_got = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit pick(input int pct);
      return $urandom_range(0, 99) < pct;
   endfunction

   // payload of beat k on each channel, computed from the index alone
   function automatic logic [A_B-1:0] aw_exp(input int k);
      return {k[1:0], 8'(k*5+3), 8'(k ^ 8'hA5), k[2:0], k[1:0] ^ 2'b10, k[5:3]};
   endfunction
   function automatic logic [A_B-1:0] ar_exp(input int k);
      return {~k[1:0], 8'(k*3+1), 8'(k), 3'(k+1), 2'(k+3), 3'(k>>1)};
   endfunction
   function automatic logic [W_B-1:0] w_exp(input int k);
      return {8'(k*7+11), k[0], k[3]};
   endfunction
   function automatic logic [B_B-1:0] b_exp(input int k);
      return {k[2:1], k[1:0] ^ 2'b01};
   endfunction
   function automatic logic [R_B-1:0] r_exp(input int k);
      return {k[1:0], 8'(k*13+5), k[3:2], k[0]};
   endfunction

   // sources on the s_clk side
   initial begin : src_aw
      bit taken = 0;
      wait (go);
      while (aw_sent < N || taken) begin
         @(negedge s_clk);
         if (taken) s_awvalid = 0;
         taken = 0;
         if (!s_awvalid && aw_sent < N && pick(80)) begin
            s_awvalid = 1;
            {s_awid, s_awaddr, s_awlen, s_awsize, s_awburst, s_awprot} = aw_exp(aw_sent);
         end
         if (s_awvalid && s_awready) begin taken = 1; aw_sent++; end
      end
   end
   initial begin : src_w
      bit taken = 0;
      wait (go);
      while (w_sent < N || taken) begin
         @(negedge s_clk);
         if (taken) s_wvalid = 0;
         taken = 0;
         if (!s_wvalid && w_sent < N && pick(70)) begin
            s_wvalid = 1; {s_wdata, s_wstrb, s_wlast} = w_exp(w_sent);
         end
         if (s_wvalid && s_wready) begin taken = 1; w_sent++; end
      end
   end
   initial begin : src_ar
      bit taken = 0;
      wait (go);
      while (ar_sent < N || taken) begin
         @(negedge s_clk);
         if (taken) s_arvalid = 0;
         taken = 0;
         if (!s_arvalid && ar_sent < N && pick(90)) begin
            s_arvalid = 1;
            {s_arid, s_araddr, s_arlen, s_arsize, s_arburst, s_arprot} = ar_exp(ar_sent);
         end
         if (s_arvalid && s_arready) begin taken = 1; ar_sent++; end
      end
   end
   // sources on the m_clk side
   initial begin : src_b
      bit taken = 0;
      wait (go);
      while (b_sent < N || taken) begin
         @(negedge m_clk);
         if (taken) m_bvalid = 0;
         taken = 0;
         if (!m_bvalid && b_sent < N && pick(75)) begin
            m_bvalid = 1; {m_bid, m_bresp} = b_exp(b_sent);
         end
         if (m_bvalid && m_bready) begin taken = 1; b_sent++; end
      end
   end
   initial begin : src_r
      bit taken = 0;
      wait (go);
      while (r_sent < N || taken) begin
         @(negedge m_clk);
         if (taken) m_rvalid = 0;
         taken = 0;
         if (!m_rvalid && r_sent < N && pick(100)) begin
            m_rvalid = 1; {m_rid, m_rdata, m_rresp, m_rlast} = r_exp(r_sent);
         end
         if (m_rvalid && m_rready) begin taken = 1; r_sent++; end
      end
   end

   // sinks: ready chosen at the falling edge, beat taken at the next rising edge
   initial begin : snk_aw
      wait (go);
      forever begin
         @(negedge m_clk);
         m_awready = aw_en && pick(60);
         if (m_awready && m_awvalid) begin
            chk(aw_got < N, "R1", "aw extra beat", aw_got, N);
            chk({m_awid, m_awaddr, m_awlen, m_awsize, m_awburst, m_awprot} == aw_exp(aw_got),
                "R1/R2", "aw payload", {m_awid, m_awaddr, m_awlen, m_awsize, m_awburst, m_awprot},
                aw_exp(aw_got));
            aw_got++;
         end
      end
   end
   initial begin : snk_w
      wait (go);
      forever begin
         @(negedge m_clk);
         m_wready = pick(85);
         if (m_wready && m_wvalid) begin
            chk(w_got < N, "R1", "w extra beat", w_got, N);
            chk({m_wdata, m_wstrb, m_wlast} == w_exp(w_got), "R1/R2", "w payload",
                {m_wdata, m_wstrb, m_wlast}, w_exp(w_got));
            w_got++;
         end
      end
   end
   initial begin : snk_ar
      wait (go);
      forever begin
         @(negedge m_clk);
         m_arready = pick(40);
         if (m_arready && m_arvalid) begin
            chk(ar_got < N, "R1", "ar extra beat", ar_got, N);
            chk({m_arid, m_araddr, m_arlen, m_arsize, m_arburst, m_arprot} == ar_exp(ar_got),
                "R1/R2", "ar payload", {m_arid, m_araddr, m_arlen, m_arsize, m_arburst, m_arprot},
                ar_exp(ar_got));
            ar_got++;
         end
      end
   end
   initial begin : snk_b
      wait (go);
      forever begin
         @(negedge s_clk);
         s_bready = pick(50);
         if (s_bready && s_bvalid) begin
            chk(b_got < N, "R1", "b extra beat", b_got, N);
            chk({s_bid, s_bresp} == b_exp(b_got), "R1/R2", "b payload", {s_bid, s_bresp}, b_exp(b_got));
            b_got++;
         end
      end
   end
   initial begin : snk_r
      wait (go);
      forever begin
         @(negedge s_clk);
         s_rready = pick(95);
         if (s_rready && s_rvalid) begin
            chk(r_got < N, "R1", "r extra beat", r_got, N);
            chk({s_rid, s_rdata, s_rresp, s_rlast} == r_exp(r_got), "R1/R2", "r payload",
                {s_rid, s_rdata, s_rresp, s_rlast}, r_exp(r_got));
            r_got++;
         end
      end
   end

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge s_clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R1 watchdog expired: actual aw%0d w%0d ar%0d b%0d r%0d expected %0d each",
                  aw_got, w_got, ar_got, b_got, r_got, N);
         finish_run();
      end
   end

   initial begin : main
      // R5: quiet while both resets are held
      repeat (3) @(posedge s_clk);
      @(negedge s_clk);
      chk({s_awready, s_wready, s_arready, s_bvalid, s_rvalid} == 5'b0, "R5", "s side in reset",
          {s_awready, s_wready, s_arready, s_bvalid, s_rvalid}, 0);
      @(negedge m_clk);
      chk({m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready} == 5'b0, "R5", "m side in reset",
          {m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 0);
      s_rst_n = 1; m_rst_n = 1;
      repeat (8) @(posedge m_clk);
      @(negedge s_clk);
      chk({s_awready, s_wready, s_arready} == 3'b111, "R5", "s readies after release",
          {s_awready, s_wready, s_arready}, 3'b111);
      chk({s_bvalid, s_rvalid} == 2'b00, "R5", "s valids idle", {s_bvalid, s_rvalid}, 0);
      @(negedge m_clk);
      chk({m_bready, m_rready} == 2'b11, "R5", "m readies after release", {m_bready, m_rready}, 2'b11);
      chk({m_awvalid, m_wvalid, m_arvalid} == 3'b000, "R5", "m valids idle",
          {m_awvalid, m_wvalid, m_arvalid}, 0);

      // R4 and R6: write-address consumer stalled, everything else running
      go = 1;
      wait (aw_sent == DEPTH);
      repeat (30) @(posedge s_clk);
      @(negedge s_clk);
      chk(aw_sent == DEPTH, "R4", "beats accepted into stalled queue", aw_sent, DEPTH);
      chk(s_awready == 1'b0, "R4", "ready low when full", s_awready, 0);
      @(negedge m_clk);
      chk(m_awvalid == 1'b1, "R4", "stalled head still offered", m_awvalid, 1);
      wait (w_got == N);
      chk(aw_got == 0, "R6", "aw delivered while stalled", aw_got, 0);
      chk(aw_sent == DEPTH, "R6", "aw accepted while stalled", aw_sent, DEPTH);
      aw_en = 1;

      // R1: drain every channel, then confirm nothing more appears
      wait (aw_got == N && w_got == N && ar_got == N && b_got == N && r_got == N);
      repeat (40) @(posedge m_clk);
      @(negedge m_clk);
      chk({m_awvalid, m_wvalid, m_arvalid} == 3'b000, "R1", "m valids after drain",
          {m_awvalid, m_wvalid, m_arvalid}, 0);
      @(negedge s_clk);
      chk({s_bvalid, s_rvalid} == 2'b00, "R1", "s valids after drain", {s_bvalid, s_rvalid}, 0);
      chk(aw_got == N && ar_got == N && b_got == N && r_got == N && w_got == N, "R2",
          "beat totals", aw_got + w_got + ar_got + b_got + r_got, 5 * N);
      done = 1;
      finish_run();
   end
endmodule